// File: doc/BRIEF.md
# Hiccup Overload Protection Controller

This block decides when a current-limited supply regulator may drive its output. It watches an overload comparator and two thermal comparators, and it produces an output-enable together with an overload flag and an over-temperature flag. All three comparator inputs are asynchronous, so each one passes through a two-stage synchroniser before any logic uses it.

A mode input selects between two overload behaviours. In static mode the output stays on, because the analog clamp handles the current, and the overload flag simply follows the comparator. In pulsed (hiccup) mode, an overload turns the output off for a long interval. The output then comes back for a short window that is one tenth as long. If an overload appears during that window, a new off interval starts. Normal running resumes, and the flag clears, only after a whole on-window passes with no overload.

Thermal shutdown uses hysteresis and overrides the overload logic. The regulator enable input gates the output ahead of everything else. Interval lengths are counted in clock ticks and set by parameters.

Top module: `hiccup_guard`

## Requirements
- R1: After reset both flags are 0 and `out_en` equals `reg_en`.
- R2: In pulsed mode (`static_limit`=0), an overload seen while running drops `out_en` and sets `ovl_flag` at the third rising edge after `ovl_raw` rises. Two of those edges are taken by the synchroniser.
- R3: The off interval lasts exactly `OFF_TICKS` clock cycles, after which `out_en` returns to 1.
- R4: The on window lasts `OFF_TICKS/ON_DIV` cycles. A synchronised overload sampled at any edge inside that window starts a fresh off interval at that same edge.
- R5: `ovl_flag` stays 1 through every off interval and on window. It clears at the edge that completes an on window with no overload.
- R6: In static mode (`static_limit`=1), `out_en` is never removed because of overload. `ovl_flag` equals the overload input delayed by two clock edges.
- R7: Raising `static_limit` during an off interval or an on window returns the controller to running at the next edge. From that edge `ovl_flag` follows the synchronised overload input.
- R8: `ovt_flag` is set at the third edge after `temp_hot` rises. It clears at the third edge after `temp_cool` is 1 with `temp_hot` 0. When both thermal inputs are 0 the flag holds its value, and when both are 1 the hot input wins. While `ovt_flag` is 1, `out_en` is 0.
- R9: `reg_en`=0 forces `out_en` to 0 without a clock edge. It has no effect on either flag, and the overload timing carries on while the output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Regulator enable; 0 keeps the output off |
| static_limit | input | 1 | 1 = static current clamp, 0 = pulsed hiccup protection |
| ovl_raw | input | 1 | Asynchronous overload comparator, 1 = overload |
| temp_hot | input | 1 | Asynchronous comparator, 1 = junction above the upper threshold |
| temp_cool | input | 1 | Asynchronous comparator, 1 = junction at or below the lower threshold |
| out_en | output | 1 | Output stage enable |
| ovl_flag | output | 1 | Overload status flag |
| ovt_flag | output | 1 | Over-temperature status flag |

## Verification
The assertions assume that every comparator input holds each level for at least two clock cycles, so the synchroniser never loses a pulse. They also assume the thermal inputs move between meaningful combinations rather than glitching. The stimulus changes inputs only two nanoseconds after a rising edge and holds each level for at least three cycles. It re-asserts overload at each possible offset inside the on window only while a full synchroniser delay still fits before the window ends. The thermal sweep starts from each flag state and applies all four input combinations.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    HS_RUN = 2'd0,
    HS_OFF = 2'd1,
    HS_ON  = 2'd2
  } hic_state_e;
endpackage

// File: rtl/hiccup_sync.sv
module hiccup_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hiccup_thermal.sv
module hiccup_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_s,
  input  logic cool_s,
  output logic ovt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovt <= 1'b0;
    else if (hot_s)  ovt <= 1'b1;
    else if (cool_s) ovt <= 1'b0;
  end

  // R8
  hot_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |=> ovt);

  // R8
  band_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovt && !cool_s) |=> ovt);
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
  import hiccup_pkg::*;
#(
  parameter int OFF_TICKS = 112_500_000,
  parameter int ON_DIV    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic static_limit,
  input  logic ovl_s,
  output logic allow,
  output logic flag
);
  localparam int ON_RAW   = OFF_TICKS / ON_DIV;
  localparam int ON_TICKS = (ON_RAW < 1) ? 1 : ON_RAW;
  localparam int CW       = $clog2(OFF_TICKS + 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);

  hic_state_e    st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= HS_RUN;
      cnt <= '0;
    end else if (static_limit) begin
      st  <= HS_RUN;
      cnt <= '0;
    end else begin
      case (st)
        HS_RUN: if (ovl_s) begin
          st  <= HS_OFF;
          cnt <= '0;
        end
        HS_OFF: if (cnt == OFF_LAST) begin
          st  <= HS_ON;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        HS_ON: if (ovl_s) begin
          st  <= HS_OFF;
          cnt <= '0;
        end else if (cnt == ON_LAST) begin
          st  <= HS_RUN;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: begin
          st  <= HS_RUN;
          cnt <= '0;
        end
      endcase
    end
  end

  assign allow = (st != HS_OFF);
  assign flag  = static_limit ? ovl_s : (st != HS_RUN);

  // R2
  trip_enters_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_RUN && !static_limit && ovl_s) |=> (st == HS_OFF));

  // R5
  off_never_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_OFF && !static_limit) |=> (st != HS_RUN));

  // R3
  off_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_OFF) |-> (cnt <= OFF_LAST));

  // R5
  clean_window_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_ON && !static_limit && !ovl_s && cnt == ON_LAST) |=> (st == HS_RUN));

  // R7
  static_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    static_limit |=> allow);
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard #(
  parameter int OFF_TICKS = 112_500_000,
  parameter int ON_DIV    = 10,
  parameter int SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_en,
  input  logic static_limit,
  input  logic ovl_raw,
  input  logic temp_hot,
  input  logic temp_cool,
  output logic out_en,
  output logic ovl_flag,
  output logic ovt_flag
);
  localparam int NIN = 3;

  logic [NIN-1:0] raw_in, syn_in;
  logic           allow;

  assign raw_in = {temp_hot, temp_cool, ovl_raw};

  hiccup_sync #(.WIDTH(NIN), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  hiccup_fsm #(.OFF_TICKS(OFF_TICKS), .ON_DIV(ON_DIV)) u_fsm (
    .clk(clk), .rst_n(rst_n), .static_limit(static_limit),
    .ovl_s(syn_in[0]), .allow(allow), .flag(ovl_flag)
  );

  hiccup_thermal u_therm (
    .clk(clk), .rst_n(rst_n), .hot_s(syn_in[2]), .cool_s(syn_in[1]),
    .ovt(ovt_flag)
  );

  assign out_en = reg_en & allow & ~ovt_flag;
endmodule

// File: tb/hiccup_guard_test.sv
module hiccup_guard_test;
  localparam int OFF = 60;
  localparam int DIV = 10;
  localparam int ON  = OFF / DIV;

  logic clk = 1'b0;
  logic rst_n, reg_en, static_limit, ovl_raw, temp_hot, temp_cool;
  logic out_en, ovl_flag, ovt_flag;
  int   vecs = 0;
  int   bad  = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  hiccup_guard #(.OFF_TICKS(OFF), .ON_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .static_limit(static_limit),
    .ovl_raw(ovl_raw), .temp_hot(temp_hot), .temp_cool(temp_cool),
    .out_en(out_en), .ovl_flag(ovl_flag), .ovt_flag(ovt_flag)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // expected vector is {out_en, ovl_flag, ovt_flag}
  task automatic chk(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {out_en, ovl_flag, ovt_flag};
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // entered the off interval at the last edge, overload already released
  task automatic ride_clean(string req);
    step(OFF - 1); chk({req, "/R3 still off"}, 3'b010);
    step(1);       chk({req, "/R3 restored"}, 3'b110);
    step(ON - 1);  chk({req, "/R5 flag held"}, 3'b110);
    step(1);       chk({req, "/R5 flag cleared"}, 3'b100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_en = 1; static_limit = 0;
    ovl_raw = 0; temp_hot = 0; temp_cool = 0;
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 reset", 3'b100);

    // R2 first trip
    ovl_raw = 1;
    step(2); chk("R2 before sync", 3'b100);
    step(1); chk("R2 trip", 3'b010);
    ovl_raw = 0;
    ride_clean("R2");

    // R4 sweep of overload offsets inside the on window
    for (int k = 0; k <= ON - 3; k++) begin
      ovl_raw = 1;
      step(3);
      ovl_raw = 0;
      step(OFF);
      step(k);
      ovl_raw = 1;
      step(2); chk("R4 window open", 3'b110);
      step(1); chk("R4 retrip", 3'b010);
      ovl_raw = 0;
      ride_clean("R4");
    end

    // R4 held overload gives a one-cycle on window
    ovl_raw = 1;
    step(3);   chk("R4 held trip", 3'b010);
    step(OFF); chk("R4 held window", 3'b110);
    step(1);   chk("R4 held retrip", 3'b010);
    ovl_raw = 0;
    ride_clean("R4 held");

    // R6 static mode
    static_limit = 1;
    step(1);
    ovl_raw = 1;
    step(1);       chk("R6 one edge", 3'b100);
    step(1);       chk("R6 flag follows", 3'b110);
    step(OFF + 5); chk("R6 no shutdown", 3'b110);
    ovl_raw = 0;
    step(1);       chk("R6 release lag", 3'b110);
    step(1);       chk("R6 flag clear", 3'b100);
    static_limit = 0;
    step(1);

    // R7 switch to static mid cycle
    ovl_raw = 1;
    step(3); chk("R7 trip", 3'b010);
    ovl_raw = 0;
    step(5);
    static_limit = 1;
    step(1); chk("R7 back to run", 3'b100);
    static_limit = 0;
    step(1); chk("R7 stays run", 3'b100);

    // R9 enable gating
    reg_en = 0;
    #1; chk("R9 disable", 3'b000);
    ovl_raw = 1;
    step(3); chk("R9 trip while disabled", 3'b010);
    ovl_raw = 0;
    reg_en = 1;
    #1; chk("R9 still in off", 3'b010);
    ride_clean("R9");
    reg_en = 0;
    #1; chk("R9 gate again", 3'b000);
    reg_en = 1;
    #1; chk("R9 regate", 3'b100);

    // R8 thermal sweep: from each flag state, every input combination
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic e;
        temp_hot  = (s == 1);
        temp_cool = (s == 0);
        step(3);
        chk("R8 start state", (s == 1) ? 3'b001 : 3'b100);
        temp_hot  = c[1];
        temp_cool = c[0];
        step(3);
        e = c[1] ? 1'b1 : (c[0] ? 1'b0 : (s == 1));
        chk("R8 hysteresis", {~e, 1'b0, e});
      end
    end
    temp_hot = 0; temp_cool = 1;
    step(3); chk("R8 final cool", 3'b100);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule